// File: doc/BRIEF.md
# Card Command Issue and Response Decoder

This block sits between the register file of a memory-card host controller and its card-side line engine. A write of a 16-bit command word, together with a 32-bit argument, is checked against the controller enable and the command in flight. An accepted word is split into its fields. The command index and argument then go to the card engine with a one-cycle start strobe. When the card side returns a response, as a byte stream with a byte count and a valid pulse, the block classifies it by the response type in the command word. It fills the response registers, and it pulses a set-vector for the status register that the surrounding controller ORs into its sticky status.

The same command word also decides the data path. An addressed-data-transfer command tells the FIFO and block logic to restart their pointers and run in the commanded direction. Every other launched command stops a transfer in progress. An initialization-sequence word carrying index 0 never reaches the card: it only completes at once.

Top module: `card_cmd_engine`

## Requirements
- R1: An accepted command word (bits 5:0 index, bit 7 init, bits 10:8 response type, bit 11 busy, bits 13:12 command type, bit 15 direction) gives, one cycle after the write, a one-cycle `card_start` with `card_index` equal to word bits 5:0 and `card_arg` equal to the written argument.
- R2: A command write is ignored while `ctrl_enable` is low, and also while a command awaits its response. An ignored write produces no start, no transfer pulse and no status, and it leaves the response registers unchanged.
- R3: Every accepted command clears all eight response registers in the cycle after the write.
- R4: A word with bit 7 set and index 0 only pulses `stat_set` = 0x0001 one cycle after the write. It gives no card start and no transfer pulse, and it waits for no response.
- R5: Response types 1, 3 and 6 need at least 4 bytes and type 2 needs 16. A shorter response gives `stat_set` = 0x0080 (timeout bit 7) alone and leaves the response registers at zero.
- R6: For type 1, the card status {byte0,byte1,byte2,byte3} is ANDed with the mask 0xFDF90000, and for type 6 its low 16 bits are ANDed with 0xE008. A non-zero result sets status bit 14.
- R7: For type 3 with enough bytes, status bit 12 is set when bit 31 of {byte0..byte3} is clear.
- R8: Response register 7-i holds {byte 2i, byte 2i+1}, with bytes at or above the required count reading as zero. Types 0, 4, 5 and 7 store nothing and never time out.
- R9: A completed command with index 12 sets status bits 0 and 2. Any other completed command sets bit 0 only.
- R10: `busy_watch` pulses together with the completion status only for a type 1 command with bit 11 set that did not time out.
- R11: Command type 3 (addressed data transfer) gives a one-cycle `xfer_start` with the card start and `xfer_dir` equal to word bit 15. Any other launched type gives a one-cycle `xfer_stop`.
- R12: Status, response registers and `busy_watch` change in the cycle after a `rsp_valid` that arrives while `cmd_busy` is high. `stat_set` is zero in every other cycle, and a `rsp_valid` with no command pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_enable | input | 1 | Controller enable; commands are dropped while low |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 16 | Command word |
| cmd_arg | input | 32 | Command argument |
| rsp_valid | input | 1 | Response from the card side is complete |
| rsp_len | input | 5 | Number of valid response bytes (0 to 16) |
| rsp_data | input | 128 | Response bytes, byte j in bits 8j+7:8j |
| card_start | output | 1 | One-cycle launch strobe to the card engine |
| card_index | output | 6 | Index of the launched command |
| card_arg | output | 32 | Argument of the launched command |
| cmd_busy | output | 1 | A launched command awaits its response |
| xfer_start | output | 1 | Restart FIFO pointers and begin a data transfer |
| xfer_stop | output | 1 | End any data transfer |
| xfer_dir | output | 1 | Direction of the started transfer |
| rsp_regs | output | 128 | Response registers, register k in bits 16k+15:16k |
| stat_set | output | 16 | One-cycle status set-vector |
| busy_watch | output | 1 | Busy-variant response completed; watch the data line for busy |

## Verification
A wrong field split or a stale launch register shows at `card_index`, `card_arg` or the transfer pulses in the very cycle after the write. A wrong decision in the response classifier shows one cycle after `rsp_valid`, as a wrong set-vector or a misplaced byte. Every response type is swept against byte counts on both sides of its need and with several byte patterns, so each path yields an exact value to compare. A stuck pending flag shows up on the next command as a missing start, and a clear that never happened shows as nonzero registers at the next launch.

// File: rtl/ccmd_pkg.sv
package ccmd_pkg;

   localparam int WORD_W    = 16;
   localparam int IDX_W     = 6;
   localparam int RSP_BYTES = 16;
   localparam int RSP_BITS  = RSP_BYTES * 8;
   localparam int LEN_W     = $clog2(RSP_BYTES + 1);

   // status set-vector bit positions
   localparam int ST_EOC     = 0;
   localparam int ST_STOPPED = 2;
   localparam int ST_TMO     = 7;
   localparam int ST_OCRLOW  = 12;
   localparam int ST_CARDERR = 14;

   // response type codes
   localparam logic [2:0] RT_NONE  = 3'd0;
   localparam logic [2:0] RT_SHORT = 3'd1;
   localparam logic [2:0] RT_LONG  = 3'd2;
   localparam logic [2:0] RT_OCR   = 3'd3;
   localparam logic [2:0] RT_RCA   = 3'd6;

   typedef struct packed {
      logic             dir;
      logic             rsv_hi;
      logic [1:0]       ctype;
      logic             busy;
      logic [2:0]       rtype;
      logic             init;
      logic             rsv_lo;
      logic [IDX_W-1:0] idx;
   } cmd_fields_t;

   function automatic cmd_fields_t split_word(input logic [WORD_W-1:0] w);
      return cmd_fields_t'(w);
   endfunction

endpackage

// File: rtl/ccmd_issue.sv
module ccmd_issue
   import ccmd_pkg::*;
#(
   parameter int         ARG_W     = 32,
   parameter logic [1:0] ADTC_CODE = 2'd3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_enable,
   input  logic              cmd_wr,
   input  logic [WORD_W-1:0] cmd_word,
   input  logic [ARG_W-1:0]  cmd_arg,
   input  logic              rsp_valid,
   output logic              accept,
   output logic              init_hit,
   output logic              take,
   output logic              pending,
   output logic [2:0]        rtype_q,
   output logic              busy_q,
   output logic [IDX_W-1:0]  idx_q,
   output logic              card_start,
   output logic [IDX_W-1:0]  card_index,
   output logic [ARG_W-1:0]  card_arg,
   output logic              xfer_start,
   output logic              xfer_stop,
   output logic              xfer_dir
);

   cmd_fields_t f;
   logic        launch;
   logic        is_adtc;
   logic        unused_bits;

   assign f           = split_word(cmd_word);
   assign unused_bits = f.rsv_hi ^ f.rsv_lo;
   assign accept      = cmd_wr & ctrl_enable & ~pending;
   assign init_hit    = accept & f.init & (f.idx == '0);
   assign launch      = accept & ~init_hit;
   assign is_adtc     = (f.ctype == ADTC_CODE);
   assign take        = pending & rsp_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending    <= 1'b0;
         rtype_q    <= '0;
         busy_q     <= 1'b0;
         idx_q      <= '0;
         card_start <= 1'b0;
         card_index <= '0;
         card_arg   <= '0;
         xfer_start <= 1'b0;
         xfer_stop  <= 1'b0;
         xfer_dir   <= 1'b0;
      end else begin
         card_start <= launch;
         xfer_start <= launch & is_adtc;
         xfer_stop  <= launch & ~is_adtc;
         if (launch) begin
            pending    <= 1'b1;
            rtype_q    <= f.rtype;
            busy_q     <= f.busy;
            idx_q      <= f.idx;
            card_index <= f.idx;
            card_arg   <= cmd_arg;
            if (is_adtc) xfer_dir <= f.dir;
         end else if (take) begin
            pending <= 1'b0;
         end
      end
   end

   p_start_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      card_start |=> !card_start);

   p_off_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !ctrl_enable) |=> (!card_start && !xfer_start && !xfer_stop));

   p_xfer_with_launch_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_start || xfer_stop) |-> card_start);

   p_inflight_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !rsp_valid) |=> (pending && !card_start));

endmodule

// File: rtl/ccmd_resp_check.sv
module ccmd_resp_check
   import ccmd_pkg::*;
#(
   parameter logic [31:0] R1_ERR_MASK = 32'hFDF9_0000,
   parameter logic [15:0] R6_ERR_MASK = 16'hE008,
   parameter int          STOP_IDX    = 12
) (
   input  logic [2:0]        rtype,
   input  logic              busy,
   input  logic [IDX_W-1:0]  idx,
   input  logic [LEN_W-1:0]  rsp_len,
   input  logic [31:0]       head,
   output logic [15:0]       stat_next,
   output logic              busy_next,
   output logic [LEN_W-1:0]  keep
);

   logic [LEN_W-1:0] need;
   logic             too_short;
   logic [31:0]      card_word;
   logic             err_hit;

   // first byte on the stream is the most significant
   assign card_word = {head[7:0], head[15:8], head[23:16], head[31:24]};

   always_comb begin
      case (rtype)
         RT_SHORT, RT_OCR, RT_RCA: need = LEN_W'(4);
         RT_LONG:                  need = LEN_W'(RSP_BYTES);
         default:                  need = '0;
      endcase
   end

   assign too_short = (need != '0) && (rsp_len < need);

   always_comb begin
      err_hit = 1'b0;
      if (rtype == RT_SHORT) err_hit = |(card_word & R1_ERR_MASK);
      if (rtype == RT_RCA)   err_hit = |(card_word[15:0] & R6_ERR_MASK);
   end

   always_comb begin
      stat_next = '0;
      if (too_short) begin
         stat_next[ST_TMO] = 1'b1;
      end else begin
         stat_next[ST_EOC]     = 1'b1;
         stat_next[ST_STOPPED] = (idx == IDX_W'(STOP_IDX));
         stat_next[ST_CARDERR] = err_hit;
         stat_next[ST_OCRLOW]  = (rtype == RT_OCR) && !card_word[31];
      end
   end

   assign busy_next = (rtype == RT_SHORT) && busy && !too_short;
   assign keep      = too_short ? '0 : need;

endmodule

// File: rtl/ccmd_resp_store.sv
module ccmd_resp_store
   import ccmd_pkg::*;
#(
   parameter int REG_W = 16,
   localparam int NREG = RSP_BITS / REG_W,
   localparam int BPR  = REG_W / 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                load,
   input  logic [LEN_W-1:0]    keep,
   input  logic [RSP_BITS-1:0] data,
   output logic [RSP_BITS-1:0] regs_flat
);

   logic [NREG-1:0][REG_W-1:0] regs_q;
   logic [NREG-1:0][REG_W-1:0] nxt;

   // byte group i lands in register NREG-1-i, earliest byte on top
   for (genvar i = 0; i < NREG; i++) begin : g_reg
      for (genvar j = 0; j < BPR; j++) begin : g_byte
         localparam int BIDX = i * BPR + j;
         assign nxt[NREG-1-i][REG_W-1-8*j -: 8] =
            (LEN_W'(BIDX) < keep) ? data[8*BIDX +: 8] : 8'h00;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    regs_q <= '0;
      else if (clr)  regs_q <= '0;
      else if (load) regs_q <= nxt;
   end

   assign regs_flat = regs_q;

   p_clear_on_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (regs_flat == '0));

   p_hold_when_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load) |=> $stable(regs_flat));

endmodule

// File: rtl/card_cmd_engine.sv
module card_cmd_engine
   import ccmd_pkg::*;
#(
   parameter int          ARG_W       = 32,
   parameter int          REG_W       = 16,
   parameter logic [31:0] R1_ERR_MASK = 32'hFDF9_0000,
   parameter logic [15:0] R6_ERR_MASK = 16'hE008,
   parameter int          STOP_IDX    = 12,
   parameter logic [1:0]  ADTC_CODE   = 2'd3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ctrl_enable,
   input  logic                cmd_wr,
   input  logic [WORD_W-1:0]   cmd_word,
   input  logic [ARG_W-1:0]    cmd_arg,
   input  logic                rsp_valid,
   input  logic [LEN_W-1:0]    rsp_len,
   input  logic [RSP_BITS-1:0] rsp_data,
   output logic                card_start,
   output logic [IDX_W-1:0]    card_index,
   output logic [ARG_W-1:0]    card_arg,
   output logic                cmd_busy,
   output logic                xfer_start,
   output logic                xfer_stop,
   output logic                xfer_dir,
   output logic [RSP_BITS-1:0] rsp_regs,
   output logic [15:0]         stat_set,
   output logic                busy_watch
);

   if ((REG_W % 8) != 0 || (RSP_BITS % REG_W) != 0) begin : g_bad_reg_w
      $error("REG_W must be a whole number of bytes dividing the long response");
   end
   if (STOP_IDX < 0 || STOP_IDX >= (1 << IDX_W)) begin : g_bad_stop
      $error("STOP_IDX does not fit the command index field");
   end
   if (ARG_W < 1) begin : g_bad_arg
      $error("ARG_W must be positive");
   end

   logic             accept, init_hit, take;
   logic [2:0]       rtype_q;
   logic             busy_q;
   logic [IDX_W-1:0] idx_q;
   logic [15:0]      stat_next;
   logic             busy_next;
   logic [LEN_W-1:0] keep;

   ccmd_issue #(
      .ARG_W     (ARG_W),
      .ADTC_CODE (ADTC_CODE)
   ) u_issue (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctrl_enable (ctrl_enable),
      .cmd_wr      (cmd_wr),
      .cmd_word    (cmd_word),
      .cmd_arg     (cmd_arg),
      .rsp_valid   (rsp_valid),
      .accept      (accept),
      .init_hit    (init_hit),
      .take        (take),
      .pending     (cmd_busy),
      .rtype_q     (rtype_q),
      .busy_q      (busy_q),
      .idx_q       (idx_q),
      .card_start  (card_start),
      .card_index  (card_index),
      .card_arg    (card_arg),
      .xfer_start  (xfer_start),
      .xfer_stop   (xfer_stop),
      .xfer_dir    (xfer_dir)
   );

   ccmd_resp_check #(
      .R1_ERR_MASK (R1_ERR_MASK),
      .R6_ERR_MASK (R6_ERR_MASK),
      .STOP_IDX    (STOP_IDX)
   ) u_check (
      .rtype     (rtype_q),
      .busy      (busy_q),
      .idx       (idx_q),
      .rsp_len   (rsp_len),
      .head      (rsp_data[31:0]),
      .stat_next (stat_next),
      .busy_next (busy_next),
      .keep      (keep)
   );

   ccmd_resp_store #(
      .REG_W (REG_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (accept),
      .load      (take),
      .keep      (keep),
      .data      (rsp_data),
      .regs_flat (rsp_regs)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_set   <= '0;
         busy_watch <= 1'b0;
      end else begin
         if (init_hit)  stat_set <= 16'(1) << ST_EOC;
         else if (take) stat_set <= stat_next;
         else           stat_set <= '0;
         busy_watch <= take & busy_next;
      end
   end

   p_init_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_enable && cmd_wr && !cmd_busy && cmd_word[7] && cmd_word[5:0] == '0)
      |=> (stat_set == 16'h0001 && !card_start && !cmd_busy));

   p_timeout_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stat_set[ST_TMO] |-> (stat_set == 16'h0080));

   p_quiet_status_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!(rsp_valid && cmd_busy) && !(cmd_wr && ctrl_enable && !cmd_busy))
      |=> (stat_set == '0 && !busy_watch));

   p_busy_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_watch |-> (stat_set[ST_EOC] && !stat_set[ST_TMO]));

endmodule

// File: tb/card_cmd_engine_test.sv
module card_cmd_engine_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ctrl_enable = 1'b0;
   logic         cmd_wr = 1'b0;
   logic [15:0]  cmd_word = '0;
   logic [31:0]  cmd_arg = '0;
   logic         rsp_valid = 1'b0;
   logic [4:0]   rsp_len = '0;
   logic [127:0] rsp_data = '0;
   logic         card_start, cmd_busy, xfer_start, xfer_stop, xfer_dir, busy_watch;
   logic [5:0]   card_index;
   logic [31:0]  card_arg;
   logic [127:0] rsp_regs;
   logic [15:0]  stat_set;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   card_cmd_engine uut (
      .clk(clk), .rst_n(rst_n), .ctrl_enable(ctrl_enable), .cmd_wr(cmd_wr),
      .cmd_word(cmd_word), .cmd_arg(cmd_arg), .rsp_valid(rsp_valid),
      .rsp_len(rsp_len), .rsp_data(rsp_data), .card_start(card_start),
      .card_index(card_index), .card_arg(card_arg), .cmd_busy(cmd_busy),
      .xfer_start(xfer_start), .xfer_stop(xfer_stop), .xfer_dir(xfer_dir),
      .rsp_regs(rsp_regs), .stat_set(stat_set), .busy_watch(busy_watch)
   );

   task automatic check(input bit ok, input string req, input logic [127:0] act,
                        input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic int need_of(input logic [2:0] rt);
      if (rt == 3'd1 || rt == 3'd3 || rt == 3'd6) return 4;
      if (rt == 3'd2) return 16;
      return 0;
   endfunction

   function automatic logic [15:0] exp_stat(input logic [15:0] w, input int len,
                                            input logic [127:0] d);
      logic [2:0]  rt = w[10:8];
      logic [31:0] cw = {d[7:0], d[15:8], d[23:16], d[31:24]};
      logic [15:0] s;
      int n = need_of(rt);
      if (n != 0 && len < n) return 16'h0080;
      s = 16'h0001;
      if (w[5:0] == 6'd12) s = s | 16'h0004;
      if (rt == 3'd1 && (cw & 32'hFDF9_0000) != 0) s = s | 16'h4000;
      if (rt == 3'd6 && (cw[15:0] & 16'hE008) != 0) s = s | 16'h4000;
      if (rt == 3'd3 && !cw[31]) s = s | 16'h1000;
      return s;
   endfunction

   function automatic logic [127:0] exp_regs(input logic [15:0] w, input int len,
                                             input logic [127:0] d);
      logic [127:0] r = '0;
      int n = need_of(w[10:8]);
      if (len < n) n = 0;
      for (int k = 0; k < 8; k++) begin
         int hi = 2 * (7 - k);
         if (hi < n)     r[16*k+8 +: 8] = d[8*hi +: 8];
         if (hi + 1 < n) r[16*k   +: 8] = d[8*(hi+1) +: 8];
      end
      return r;
   endfunction

   function automatic logic [127:0] pattern(input int s);
      logic [127:0] d;
      for (int j = 0; j < 16; j++) d[8*j +: 8] = 8'(j * 29 + s * 83 + 7);
      return d;
   endfunction

   // full command: write, check launch, respond, check result
   task automatic run_cmd(input logic [15:0] w, input logic [31:0] a,
                          input int len, input logic [127:0] d);
      logic [15:0]  es = exp_stat(w, len, d);
      logic [127:0] er = exp_regs(w, len, d);
      bit           adtc = (w[13:12] == 2'd3);
      bit           ebw = (w[10:8] == 3'd1) && w[11] && (es != 16'h0080);
      @(negedge clk);
      cmd_word = w; cmd_arg = a; cmd_wr = 1'b1;
      @(posedge clk); #1;
      check(card_start === 1'b1, "R1 start", 128'(card_start), 128'd1);
      check(card_index === w[5:0], "R1 index", 128'(card_index), 128'(w[5:0]));
      check(card_arg === a, "R1 arg", 128'(card_arg), 128'(a));
      check(rsp_regs === '0, "R3 cleared", rsp_regs, '0);
      check(xfer_start === adtc && xfer_stop === !adtc, "R11 xfer pulse",
            128'({xfer_start, xfer_stop}), 128'({adtc, !adtc}));
      if (adtc) check(xfer_dir === w[15], "R11 dir", 128'(xfer_dir), 128'(w[15]));
      @(negedge clk);
      cmd_wr = 1'b0;
      rsp_valid = 1'b1; rsp_len = 5'(len); rsp_data = d;
      @(posedge clk); #1;
      check(card_start === 1'b0, "R1 one cycle", 128'(card_start), 128'd0);
      check(stat_set === es, "R5 R6 R7 R9 status", 128'(stat_set), 128'(es));
      check(rsp_regs === er, "R8 packing", rsp_regs, er);
      check(busy_watch === ebw, "R10 busy", 128'(busy_watch), 128'(ebw));
      check(cmd_busy === 1'b0, "R12 done", 128'(cmd_busy), 128'd0);
      @(negedge clk);
      rsp_valid = 1'b0;
      @(posedge clk); #1;
      check(stat_set === '0 && busy_watch === 1'b0, "R12 pulse",
            128'(stat_set), 128'd0);
      check(rsp_regs === er, "R12 hold", rsp_regs, er);
   endtask

   function automatic logic [15:0] mk(input bit dir, input logic [1:0] ct,
                                      input bit bsy, input logic [2:0] rt,
                                      input bit ini, input logic [5:0] idx);
      return {dir, 1'b0, ct, bsy, rt, ini, 1'b0, idx};
   endfunction

   initial begin
      #(20 * 200000);
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [127:0] d0;
      logic [127:0] held;
      int lens[5] = '{0, 3, 4, 15, 16};
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      check(card_start === 0 && cmd_busy === 0 && stat_set === 0 && rsp_regs === 0,
            "R12 reset state", 128'({card_start, cmd_busy, stat_set}), 128'd0);
      ctrl_enable = 1'b1;

      // sweep: every response type against byte counts around its need
      for (int rt = 0; rt < 8; rt++) begin
         for (int li = 0; li < 5; li++) begin
            for (int b = 0; b < 2; b++) begin
               int s = rt * 10 + li * 2 + b;
               logic [5:0] idx = (li == 4 && b == 0) ? 6'd12 : 6'(rt * 7 + li + 1);
               run_cmd(mk(b[0], 2'(li), b[0], 3'(rt), 1'b0, idx),
                       32'h1000_0000 + 32'(s * 977), lens[li], pattern(s));
            end
         end
      end

      // R6 directed: type 1 with zero status, with out-of-range bit
      d0 = '0;
      run_cmd(mk(0, 2'd1, 0, 3'd1, 0, 6'd13), 32'h0, 4, d0);
      d0[7:0] = 8'h80;
      run_cmd(mk(0, 2'd1, 0, 3'd1, 0, 6'd13), 32'h0, 4, d0);
      // R6 type 6: upper half ignored, low bit 3 flagged
      d0 = '0; d0[7:0] = 8'hFF; d0[15:8] = 8'hFF;
      run_cmd(mk(0, 2'd2, 0, 3'd6, 0, 6'd3), 32'h5, 4, d0);
      d0 = '0; d0[31:24] = 8'h08;
      run_cmd(mk(0, 2'd2, 0, 3'd6, 0, 6'd3), 32'h5, 4, d0);
      // R7 type 3 with bit 31 set and clear
      d0 = '0; d0[7:0] = 8'h80;
      run_cmd(mk(0, 2'd1, 0, 3'd3, 0, 6'd41), 32'h0, 4, d0);
      d0 = '0; d0[7:0] = 8'h7F;
      run_cmd(mk(0, 2'd1, 0, 3'd3, 0, 6'd41), 32'h0, 4, d0);
      // R9 stop command with busy type 1
      run_cmd(mk(0, 2'd2, 1, 3'd1, 0, 6'd12), 32'h0, 4, 128'h0);
      // R4 init bit with nonzero index is a normal launch
      run_cmd(mk(0, 2'd0, 0, 3'd0, 1, 6'd5), 32'hABCD, 0, 128'h0);

      // R4 init with index 0
      run_cmd(mk(0, 2'd0, 0, 3'd2, 0, 6'd2), 32'h0, 16, pattern(7));
      held = exp_regs(mk(0, 2'd0, 0, 3'd2, 0, 6'd2), 16, pattern(7));
      @(negedge clk);
      cmd_word = mk(0, 2'd3, 0, 3'd1, 1, 6'd0); cmd_wr = 1'b1;
      @(posedge clk); #1;
      check(stat_set === 16'h0001, "R4 status", 128'(stat_set), 128'h1);
      check(card_start === 0 && xfer_start === 0 && xfer_stop === 0 && cmd_busy === 0,
            "R4 no launch", 128'({card_start, xfer_start, xfer_stop, cmd_busy}), 128'd0);
      check(rsp_regs === '0, "R3 init clears", rsp_regs, '0);
      @(negedge clk); cmd_wr = 1'b0;
      @(posedge clk); #1;
      check(stat_set === '0, "R4 one pulse", 128'(stat_set), 128'd0);

      // R2 disabled write is ignored
      run_cmd(mk(0, 2'd0, 0, 3'd2, 0, 6'd2), 32'h0, 16, pattern(9));
      held = exp_regs(mk(0, 2'd0, 0, 3'd2, 0, 6'd2), 16, pattern(9));
      @(negedge clk);
      ctrl_enable = 1'b0;
      cmd_word = mk(0, 2'd3, 0, 3'd1, 0, 6'd9); cmd_arg = 32'h77; cmd_wr = 1'b1;
      @(posedge clk); #1;
      check(card_start === 0 && xfer_start === 0 && xfer_stop === 0 && cmd_busy === 0,
            "R2 disabled", 128'({card_start, xfer_start, xfer_stop, cmd_busy}), 128'd0);
      check(stat_set === '0, "R2 disabled status", 128'(stat_set), 128'd0);
      check(rsp_regs === held, "R2 regs kept", rsp_regs, held);
      @(negedge clk); cmd_wr = 1'b0; ctrl_enable = 1'b1;

      // R12 stray response ignored
      rsp_valid = 1'b1; rsp_len = 5'd16; rsp_data = pattern(3);
      @(posedge clk); #1;
      check(stat_set === '0 && rsp_regs === held, "R12 stray response",
            128'(stat_set), 128'd0);
      @(negedge clk); rsp_valid = 1'b0;

      // R2 write while a command is in flight
      cmd_word = mk(0, 2'd0, 0, 3'd0, 0, 6'd12); cmd_arg = 32'h1; cmd_wr = 1'b1;
      @(posedge clk); #1;
      check(card_start === 1'b1, "R1 start A", 128'(card_start), 128'd1);
      @(negedge clk);
      cmd_word = mk(0, 2'd3, 0, 3'd0, 0, 6'd3); cmd_arg = 32'h2;
      @(posedge clk); #1;
      check(card_start === 0 && xfer_start === 0 && card_index === 6'd12,
            "R2 in flight", 128'({card_start, card_index}), 128'(12));
      @(negedge clk); cmd_wr = 1'b0; rsp_valid = 1'b1; rsp_len = 5'd0;
      @(posedge clk); #1;
      check(stat_set === 16'h0005, "R9 first command kept", 128'(stat_set), 128'h5);
      @(negedge clk); rsp_valid = 1'b0;
      @(posedge clk); #1;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule